// File: doc/BRIEF.md
# Auto-Reload Timer with Coherent Byte Access

This block is a wide up-counter that reloads itself from a hidden reload register each time it wraps past its all-ones value. Software reaches it through a narrow register port: two byte addresses cover the counter, and a third holds the control bits. A write to the two counter addresses fills the reload register, while a read of the same addresses returns the live count. A staging latch keeps the low byte until the high byte commits the whole value. A snapshot latch freezes the low byte at the moment the high byte is read.

The count advances on tick enables rather than on a second clock. The control register picks the tick source: either every system clock or a slow low-power enable pulse supplied from outside. While the power-down input is high, only the slow source keeps the timer running. Each wrap sets a sticky overflow flag that drives the interrupt line, so the flag can bring the system out of power-down. Software clears the flag by writing 0 to it.

Top module: `reload_timer`

## Requirements
- R1: After reset the counter, reload register, run bit, source field and overflow flag are all zero, and `irq` is low.
- R2: While the run bit (control bit 0) is 1, the counter rises by exactly one on each tick. While the run bit is 0, the counter holds its value.
- R3: On a tick that finds the counter at all ones, the counter takes the reload value and the overflow flag (control bit 7) is set. `irq` follows the flag.
- R4: A write to address 0 only stages a low byte. A write to address 1 commits {written byte, staged low byte} to the reload register. A low-byte write on its own changes neither the reload value nor the counter.
- R5: A commit while the run bit is 0 copies the new value into the counter at once. While the run bit is 1, the counter carries on, and the new value is used at the next wrap.
- R6: A read of address 1 returns the live high byte and latches the live low byte. A read of address 0 returns that latched byte, so the two reads form one coherent count.
- R7: The source field (control bits 2:1) selects the tick. Code 2'b10 ticks only on cycles where `slow_tick_en` is high. Codes 2'b00, 2'b01 and 2'b11 tick on every system clock.
- R8: While `power_down` is high, system-clock ticks stop. Slow ticks under code 2'b10 continue.
- R9: A control write with bit 7 at 0 clears the flag, and one with bit 7 at 1 leaves it alone. An overflow in the same cycle as a clear leaves the flag set.
- R10: Address 2 reads back {flag, zeros, source, run} in bits 7, 2:1 and 0. Address 3 reads as zero, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (the high-byte read has a side effect) |
| bus_addr | input | 2 | Register address: 0 low byte, 1 high byte, 2 control |
| bus_wdata | input | BYTE_W | Write data |
| bus_rdata | output | BYTE_W | Read data for `bus_addr`, combinational |
| slow_tick_en | input | 1 | One-cycle enable from the slow low-power clock |
| power_down | input | 1 | High while the system is in power-down |
| irq | output | 1 | Overflow interrupt and wake request (the sticky flag) |

## Verification
The assertions assume that `bus_wr` and `bus_rd` are never high in the same cycle. They also assume that software follows the ordering rules: the low byte is written before the high byte, and the high byte is read before the low byte. The stimulus drives one strobe per cycle and always uses those orders. `slow_tick_en` is driven as single-cycle pulses separated by idle cycles, as a synchronised slow-clock enable would be. Expected counts come from the number of tick edges between the run-bit writes, folded through the wrap to the reload value.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   typedef enum logic [1:0] {
      SRC_SYS_A = 2'b00,
      SRC_SYS_B = 2'b01,
      SRC_SLOW  = 2'b10,
      SRC_SYS_C = 2'b11
   } tick_src_e;

   localparam int ADDR_W = 2;
   localparam logic [ADDR_W-1:0] A_LO  = 2'd0;
   localparam logic [ADDR_W-1:0] A_HI  = 2'd1;
   localparam logic [ADDR_W-1:0] A_CTL = 2'd2;

   localparam int CTL_RUN  = 0;
   localparam int CTL_SRC  = 1;
   localparam int CTL_FLAG = 7;

endpackage

// File: rtl/tmr_tick_sel.sv
module tmr_tick_sel
   import tmr_pkg::*;
#(
   parameter bit PD_STOPS_SYS = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      run,
   input  tick_src_e src,
   input  logic      slow_en,
   input  logic      pd,
   output logic      tick
);

   logic sys_ok;

   generate
      if (PD_STOPS_SYS) begin : g_pd_gate
         assign sys_ok = ~pd;
      end else begin : g_no_gate
         assign sys_ok = 1'b1;
      end
   endgenerate

   always_comb begin
      if (!run)
         tick = 1'b0;
      else if (src == SRC_SLOW)
         tick = slow_en;
      else
         tick = sys_ok;
   end

   // R8: in power-down only the slow source may tick
   assert_pd_sys_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pd && src != SRC_SLOW && PD_STOPS_SYS) |-> !tick);

   // R7: slow source ticks only with its enable
   assert_slow_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (src == SRC_SLOW && !slow_en) |-> !tick);

endmodule

// File: rtl/tmr_access.sv
module tmr_access
   import tmr_pkg::*;
#(
   parameter int BYTE_W = 8,
   localparam int CNT_W = 2 * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic              rd,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BYTE_W-1:0] wdata,
   input  logic [CNT_W-1:0]  cnt,
   input  logic              flag,
   output logic [BYTE_W-1:0] rdata,
   output logic              commit,
   output logic [CNT_W-1:0]  commit_val,
   output logic              run,
   output tick_src_e         src,
   output logic              clr_req
);

   logic [BYTE_W-1:0] stage_lo;
   logic [BYTE_W-1:0] snap_lo;

   assign commit     = wr && (addr == A_HI);
   assign commit_val = {wdata, stage_lo};
   assign clr_req    = wr && (addr == A_CTL) && !wdata[CTL_FLAG];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_lo <= '0;
         snap_lo  <= '0;
         run      <= 1'b0;
         src      <= SRC_SYS_A;
      end else begin
         if (wr && addr == A_LO)
            stage_lo <= wdata;
         if (wr && addr == A_CTL) begin
            run <= wdata[CTL_RUN];
            src <= tick_src_e'(wdata[CTL_SRC +: 2]);
         end
         if (rd && addr == A_HI)
            snap_lo <= cnt[BYTE_W-1:0];
      end
   end

   always_comb begin
      rdata = '0;
      case (addr)
         A_LO:  rdata = snap_lo;
         A_HI:  rdata = cnt[CNT_W-1:BYTE_W];
         A_CTL: begin
            rdata[CTL_RUN]      = run;
            rdata[CTL_SRC +: 2] = src;
            rdata[CTL_FLAG]     = flag;
         end
         default: rdata = '0;
      endcase
   end

   // R6: a high-byte read freezes the low byte of that same count
   assert_snap_coherent_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && addr == A_HI) |=> snap_lo == $past(cnt[BYTE_W-1:0]));

   // R4: staged byte is untouched by any access other than a low-byte write
   assert_stage_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr && addr == A_LO) |=> $stable(stage_lo));

endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             run,
   input  logic             commit,
   input  logic [CNT_W-1:0] commit_val,
   input  logic             clr_req,
   output logic [CNT_W-1:0] cnt,
   output logic             flag
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] reload;
   logic             wrap;
   logic             direct_load;

   assign wrap        = tick && (cnt == CNT_MAX);
   assign direct_load = commit && !run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reload <= '0;
         cnt    <= '0;
         flag   <= 1'b0;
      end else begin
         if (commit)
            reload <= commit_val;
         if (wrap)
            cnt <= reload;
         else if (tick)
            cnt <= cnt + 1'b1;
         else if (direct_load)
            cnt <= commit_val;
         if (wrap)
            flag <= 1'b1;
         else if (clr_req)
            flag <= 1'b0;
      end
   end

   // R3: wrap loads the reload value held before this edge and raises the flag
   assert_wrap_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && cnt == CNT_MAX) |=> (cnt == $past(reload)) && flag);

   // R2: ordinary tick advances by one
   assert_step_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && cnt != CNT_MAX) |=> cnt == $past(cnt) + 1'b1);

   // R2 / R5: without tick or stopped commit the count holds
   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !(commit && !run)) |=> $stable(cnt));

   // R9: flag never falls on a wrap cycle
   assert_flag_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && cnt == CNT_MAX && clr_req) |=> flag);

endmodule

// File: rtl/reload_timer.sv
module reload_timer
   import tmr_pkg::*;
#(
   parameter int BYTE_W       = 8,
   parameter int CNT_W        = 16,
   parameter bit PD_STOPS_SYS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [1:0]        bus_addr,
   input  logic [BYTE_W-1:0] bus_wdata,
   output logic [BYTE_W-1:0] bus_rdata,
   input  logic              slow_tick_en,
   input  logic              power_down,
   output logic              irq
);

   generate
      if (CNT_W != 2 * BYTE_W) begin : g_bad_width
         $error("reload_timer: CNT_W must be twice BYTE_W");
      end
      if (BYTE_W < 8) begin : g_bad_byte
         $error("reload_timer: BYTE_W must hold the control layout");
      end
   endgenerate

   logic             tick;
   logic             run;
   tick_src_e        src;
   logic             commit;
   logic [CNT_W-1:0] commit_val;
   logic             clr_req;
   logic [CNT_W-1:0] cnt;
   logic             flag;

   tmr_tick_sel #(
      .PD_STOPS_SYS(PD_STOPS_SYS)
   ) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .src     (src),
      .slow_en (slow_tick_en),
      .pd      (power_down),
      .tick    (tick)
   );

   tmr_access #(
      .BYTE_W(BYTE_W)
   ) u_access (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr         (bus_wr),
      .rd         (bus_rd),
      .addr       (bus_addr),
      .wdata      (bus_wdata),
      .cnt        (cnt),
      .flag       (flag),
      .rdata      (bus_rdata),
      .commit     (commit),
      .commit_val (commit_val),
      .run        (run),
      .src        (src),
      .clr_req    (clr_req)
   );

   tmr_core #(
      .CNT_W(CNT_W)
   ) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .run        (run),
      .commit     (commit),
      .commit_val (commit_val),
      .clr_req    (clr_req),
      .cnt        (cnt),
      .flag       (flag)
   );

   assign irq = flag;

   // R3: interrupt line only rises as the result of a tick
   assert_irq_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(tick));

endmodule

// File: tb/test_reload_timer.sv
module test_reload_timer;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [7:0] bus_wdata = 8'd0;
   logic [7:0] bus_rdata;
   logic       slow_tick_en = 1'b0;
   logic       power_down = 1'b0;
   logic       irq;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   reload_timer i_reload_timer (
      .clk          (clk),
      .rst_n        (rst_n),
      .bus_wr       (bus_wr),
      .bus_rd       (bus_rd),
      .bus_addr     (bus_addr),
      .bus_wdata    (bus_wdata),
      .bus_rdata    (bus_rdata),
      .slow_tick_en (slow_tick_en),
      .power_down   (power_down),
      .irq          (irq)
   );

   task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      bus_rd = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic idle(input logic slow);
      slow_tick_en = slow;
      @(negedge clk);
      slow_tick_en = 1'b0;
   endtask

   task automatic ld(input logic [15:0] v);
      wr(2'd0, v[7:0]);
      wr(2'd1, v[15:8]);
   endtask

   task automatic rd16(output logic [15:0] v);
      logic [7:0] h, l;
      rd(2'd1, h);
      rd(2'd0, l);
      v = {h, l};
   endtask

   function automatic logic [15:0] adv(input logic [15:0] s, input int t, input logic [15:0] r);
      logic [15:0] v = s;
      for (int i = 0; i < t; i++) v = (v == 16'hFFFF) ? r : v + 16'd1;
      return v;
   endfunction

   initial begin
      #4000000;
      n_bad++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("test done: total=%0d bad=%0d", n_chk + 1, n_bad);
      $finish;
   end

   initial begin
      logic [7:0]  b;
      logic [15:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 irq", {15'd0, irq}, 16'd0);
      rd(2'd2, b); chk("R1 ctl", {8'd0, b}, 16'h0000);
      rd16(v);     chk("R1 count", v, 16'h0000);

      // R4 / R5: stopped commit copies at once; lone low write has no effect
      ld(16'hA55A);
      rd16(v); chk("R5 stopped commit", v, 16'hA55A);
      wr(2'd0, 8'h77);
      rd16(v); chk("R4 low write only", v, 16'hA55A);
      wr(2'd1, 8'h3C);
      rd16(v); chk("R4 commit with staged low", v, 16'h3C77);

      // R2 / R3 sweep across the wrap
      for (int n = 0; n < 7; n++) begin
         ld(16'hFFFC);
         wr(2'd2, 8'h01);
         repeat (n) idle(1'b0);
         wr(2'd2, 8'h00);
         rd16(v); chk("R2 R3 count sweep", v, adv(16'hFFFC, n + 1, 16'hFFFC));
         repeat (4) idle(1'b0);
         rd16(v); chk("R2 hold while stopped", v, adv(16'hFFFC, n + 1, 16'hFFFC));
         wr(2'd2, 8'h00);
      end

      // R3 flag and irq on wrap
      ld(16'hFFFF);
      wr(2'd2, 8'h01);
      wr(2'd2, 8'h80);
      rd(2'd2, b); chk("R3 flag set", {8'd0, b}, 16'h0080);
      chk("R3 irq", {15'd0, irq}, 16'd1);
      rd16(v); chk("R3 reload on wrap", v, 16'hFFFF);

      // R9 clear semantics
      wr(2'd2, 8'h80);
      rd(2'd2, b); chk("R9 write 1 keeps", {8'd0, b}, 16'h0080);
      wr(2'd2, 8'h00);
      rd(2'd2, b); chk("R9 write 0 clears", {8'd0, b}, 16'h0000);
      chk("R9 irq low", {15'd0, irq}, 16'd0);
      ld(16'hFFFF);
      wr(2'd2, 8'h01);
      wr(2'd2, 8'h01);
      rd(2'd2, b); chk("R9 overflow beats clear", {8'd0, b}, 16'h0081);
      wr(2'd2, 8'h00);
      wr(2'd2, 8'h00);
      rd(2'd2, b); chk("R9 cleared after stop", {8'd0, b}, 16'h0000);

      // R5 commit while running takes effect at next wrap
      ld(16'hFFF0);
      wr(2'd2, 8'h01);
      wr(2'd0, 8'h34);
      wr(2'd1, 8'h12);
      repeat (20) idle(1'b0);
      wr(2'd2, 8'h00);
      rd16(v); chk("R5 running commit", v, adv(16'hFFF0, 23, 16'h1234));
      wr(2'd2, 8'h00);

      // R7 system-clock codes
      for (int s = 0; s < 4; s++) begin
         if (s != 2) begin
            ld(16'h0100);
            wr(2'd2, 8'(s * 2 + 1));
            rd(2'd2, b); chk("R10 ctl readback", {8'd0, b}, 16'(s * 2 + 1));
            repeat (2) idle(1'b0);
            wr(2'd2, 8'h00);
            rd16(v); chk("R7 system code", v, 16'h0104);
         end
      end

      // R7 slow code: only enable pulses count
      ld(16'h0200);
      wr(2'd2, 8'h05);
      for (int i = 0; i < 6; i++) idle(i[0]);
      wr(2'd2, 8'h00);
      rd16(v); chk("R7 slow pulses", v, 16'h0203);

      // R8 power-down
      power_down = 1'b1;
      ld(16'h0300);
      wr(2'd2, 8'h01);
      repeat (5) idle(1'b0);
      wr(2'd2, 8'h00);
      rd16(v); chk("R8 sys stopped in pd", v, 16'h0300);
      wr(2'd2, 8'h05);
      idle(1'b1); idle(1'b0); idle(1'b1);
      wr(2'd2, 8'h00);
      rd16(v); chk("R8 slow runs in pd", v, 16'h0302);
      power_down = 1'b0;

      // R6 coherent read across a carry
      ld(16'h12FE);
      wr(2'd2, 8'h01);
      idle(1'b0);
      rd16(v); chk("R6 coherent pair", v, 16'h12FF);
      wr(2'd2, 8'h00);
      rd16(v); chk("R6 live after stop", v, 16'h1302);

      // R10 unused address
      wr(2'd3, 8'hFF);
      rd(2'd2, b); chk("R10 addr3 write ignored", {8'd0, b}, 16'h0000);
      rd(2'd3, b); chk("R10 addr3 reads zero", {8'd0, b}, 16'h0000);
      rd16(v); chk("R10 count untouched", v, 16'h1302);

      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule